// File: doc/BRIEF.md
# Half/Single Precision Format Converter

This block converts a floating-point value between the 16-bit and the 32-bit IEEE 754 binary formats. A single select input picks the direction for each cycle. The conversion logic is combinational. A register stage holds the converted value and a 4-bit exception flag vector, so every result appears one clock after its operand.

Going from half to single is always exact. Denormal halves are normalised, not flushed. Going from single to half rounds to nearest with ties to even. Results too small for a normal half become half denormals, not zero. Results too large become infinity.

NaNs do not follow the usual rule of keeping the leading significand bits. Instead, the payload moves as two separate pieces: the two highest significand bits of one format map to the two highest of the other, and the eight lowest bits map to the eight lowest. A half NaN whose mapped significand would be all zero gets bit 0 set, so the result stays a NaN.

Top module: `fp_hs_conv`

## Requirements
- R1: While `rst_n` is low, `dout` and `flags` are zero, and asserting reset clears them at once.
- R2: A result is registered: the value driven on `dout`/`flags` at the first rising edge after an operand is applied and holds until the next edge. With `to_half`=0 only `din[15:0]` is used. With `to_half`=1 the half result is in `dout[15:0]` and `dout[31:16]` is zero. Flag bits are `flags[3]`=invalid, `flags[2]`=overflow, `flags[1]`=underflow and `flags[0]`=inexact.
- R3: Half-to-single converts zeros, infinities, normals and denormals exactly, keeps the sign, and raises none of overflow, underflow or inexact.
- R4: A half NaN (exponent 5'h1F, significand nonzero) becomes a single with the same sign, exponent 8'hFF, bits 22..21 equal to half bits 9..8, bits 7..0 equal to half bits 7..0, and bits 20..8 zero.
- R5: A single NaN (exponent 8'hFF, significand nonzero) becomes a half with the same sign, exponent 5'h1F, bits 9..8 equal to single bits 22..21 and bits 7..0 equal to single bits 7..0. If those ten bits are all zero, bit 0 is set to 1.
- R6: A signaling NaN input raises invalid in either direction. A signaling NaN is one whose top significand bit (bit 9 for half, bit 22 for single) is 0. A quiet NaN and every non-NaN input leave invalid clear.
- R7: Single-to-half rounds to nearest, ties to even. Inexact is set exactly when discarded bits are nonzero.
- R8: A single-to-half result whose rounded magnitude reaches 65520 or more becomes a signed infinity (magnitude 15'h7C00) with overflow and inexact set.
- R9: Single-to-half values below 2^-14 before rounding produce half denormals, or zero, or the smallest normal when rounding carries into it, with no flushing. Underflow is raised when such a value is also inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| to_half | input | 1 | 0: half to single, 1: single to half |
| din | input | 32 | Operand; a half operand sits in bits 15..0 |
| dout | output | 32 | Registered converted value |
| flags | output | 4 | Registered flags {invalid, overflow, underflow, inexact} |

## Verification
Both the converted value and its flags are due exactly one rising edge after the operand and `to_half` are applied. They stay there until the next edge. The bench changes operands on the falling edge and reads `dout` and `flags` on the following falling edge, half a period after the capturing edge. One directed check also reads just after a change, to confirm the output still shows the previous result. Reset is checked asynchronously, a moment after `rst_n` falls, without waiting for an edge.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned SGL_W   = 32;
  localparam int unsigned H_EXP_W = 5;
  localparam int unsigned H_MAN_W = 10;
  localparam int unsigned S_EXP_W = 8;
  localparam int unsigned S_MAN_W = 23;
  localparam int unsigned MAN_GAP = S_MAN_W - H_MAN_W;          // 13
  localparam int unsigned EXP_GAP = 127 - 15;                    // 112
  localparam int unsigned FLAG_W  = 4;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fp_flags_t;

  // round-to-nearest-even increment decision
  function automatic logic rne_bump(input logic lsb, input logic guard, input logic sticky);
    return guard & (sticky | lsb);
  endfunction

  // index of the highest set bit of a half significand
  function automatic logic [4:0] top_one(input logic [H_MAN_W-1:0] m);
    logic [4:0] idx;
    idx = '0;
    for (int i = 0; i < int'(H_MAN_W); i++)
      if (m[i]) idx = 5'(i);
    return idx;
  endfunction

  // complete half-to-single value mapping (always exact)
  function automatic logic [SGL_W-1:0] widen(input logic [HALF_W-1:0] h);
    logic                 sg;
    logic [H_EXP_W-1:0]   e;
    logic [H_MAN_W-1:0]   m;
    logic [4:0]           p;
    logic [S_MAN_W:0]     nrm;
    sg = h[HALF_W-1];
    e  = h[HALF_W-2:H_MAN_W];
    m  = h[H_MAN_W-1:0];
    p  = top_one(m);
    nrm = {14'b0, m} << (5'd23 - p);
    if (&e) begin
      if (m == '0) widen = {sg, 8'hFF, 23'b0};
      else         widen = {sg, 8'hFF, m[9:8], 13'b0, m[7:0]};
    end else if (e == '0) begin
      if (m == '0) widen = {sg, 31'b0};
      else         widen = {sg, 8'({3'b0, p}) + 8'd103, nrm[S_MAN_W-1:0]};
    end else begin
      widen = {sg, 8'({3'b0, e}) + 8'(EXP_GAP), m, 13'b0};
    end
  endfunction
endpackage

// File: rtl/fpc_h2s.sv
module fpc_h2s
  import fpc_pkg::*;
(
  input  logic [HALF_W-1:0] h_in,
  output logic [SGL_W-1:0]  s_out,
  output fp_flags_t         flg,
  output logic              nan_seen
);
  logic exp_full, man_nz, quiet_bit;

  assign exp_full  = &h_in[HALF_W-2:H_MAN_W];
  assign man_nz    = |h_in[H_MAN_W-1:0];
  assign quiet_bit = h_in[H_MAN_W-1];
  assign nan_seen  = exp_full & man_nz;

  assign s_out = widen(h_in);

  always_comb begin
    flg         = '0;
    flg.invalid = nan_seen & ~quiet_bit;
  end
endmodule

// File: rtl/fpc_s2h.sv
module fpc_s2h
  import fpc_pkg::*;
(
  input  logic [SGL_W-1:0]  s_in,
  output logic [HALF_W-1:0] h_out,
  output fp_flags_t         flg,
  output logic              nan_seen
);
  localparam int unsigned EXT_W   = 37;
  localparam int unsigned MAX_SH  = 26;

  logic                 sg;
  logic [S_EXP_W-1:0]   ex;
  logic [S_MAN_W-1:0]   mn;
  logic signed [9:0]    he;
  logic signed [9:0]    sh_full;
  logic [5:0]           sh;
  logic [H_MAN_W-1:0]   payload;
  logic [H_MAN_W-1:0]   payload_fix;

  // normal-range path
  logic                 n_guard, n_sticky, n_up;
  logic [14:0]          n_sum;
  // denormal-range path
  logic [EXT_W-1:0]     d_ext;
  logic                 d_guard, d_sticky, d_up;
  logic [10:0]          d_res;

  assign sg = s_in[SGL_W-1];
  assign ex = s_in[SGL_W-2:S_MAN_W];
  assign mn = s_in[S_MAN_W-1:0];
  assign he = $signed({2'b00, ex}) - 10'sd112;

  assign nan_seen    = (&ex) & (|mn);
  assign payload     = {mn[22:21], mn[7:0]};
  assign payload_fix = (payload == '0) ? 10'd1 : payload;

  assign n_guard  = mn[MAN_GAP-1];
  assign n_sticky = |mn[MAN_GAP-2:0];
  assign n_up     = rne_bump(mn[MAN_GAP], n_guard, n_sticky);
  assign n_sum    = {he[4:0], mn[S_MAN_W-1:MAN_GAP]} + {14'b0, n_up};

  assign sh_full  = 10'sd14 - he;
  assign sh       = (sh_full > 10'sd26) ? 6'(MAX_SH) : sh_full[5:0];
  assign d_ext    = EXT_W'({1'b1, mn, 26'b0} >> sh);
  assign d_guard  = d_ext[25];
  assign d_sticky = |d_ext[24:0];
  assign d_up     = rne_bump(d_ext[26], d_guard, d_sticky);
  assign d_res    = d_ext[36:26] + {10'b0, d_up};

  always_comb begin
    h_out = '0;
    flg   = '0;
    if (&ex) begin
      if (mn == '0) begin
        h_out = {sg, 5'h1F, 10'b0};
      end else begin
        h_out       = {sg, 5'h1F, payload_fix};
        flg.invalid = ~mn[S_MAN_W-1];
      end
    end else if (ex == '0) begin
      h_out         = {sg, 15'b0};
      flg.inexact   = |mn;
      flg.underflow = |mn;
    end else if (he >= 10'sd31) begin
      h_out        = {sg, 5'h1F, 10'b0};
      flg.overflow = 1'b1;
      flg.inexact  = 1'b1;
    end else if (he >= 10'sd1) begin
      h_out        = {sg, n_sum};
      flg.inexact  = n_guard | n_sticky;
      flg.overflow = &n_sum[14:10];
    end else begin
      h_out         = {sg, 4'b0, d_res};
      flg.inexact   = d_guard | d_sticky;
      flg.underflow = d_guard | d_sticky;
    end
  end
endmodule

// File: rtl/fp_hs_conv.sv
module fp_hs_conv
  import fpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              to_half,
  input  logic [SGL_W-1:0]  din,
  output logic [SGL_W-1:0]  dout,
  output logic [FLAG_W-1:0] flags
);
  logic [SGL_W-1:0]  wide_res;
  logic [HALF_W-1:0] narrow_res;
  fp_flags_t         wide_flg, narrow_flg;
  logic              wide_nan, narrow_nan, nan_sel;
  logic [SGL_W-1:0]  nxt_val;
  fp_flags_t         nxt_flg;
  logic              dir_q;

  fpc_h2s u_h2s (
    .h_in     (din[HALF_W-1:0]),
    .s_out    (wide_res),
    .flg      (wide_flg),
    .nan_seen (wide_nan)
  );

  fpc_s2h u_s2h (
    .s_in     (din),
    .h_out    (narrow_res),
    .flg      (narrow_flg),
    .nan_seen (narrow_nan)
  );

  assign nan_sel = to_half ? narrow_nan : wide_nan;
  assign nxt_val = to_half ? {{(SGL_W-HALF_W){1'b0}}, narrow_res} : wide_res;
  assign nxt_flg = to_half ? narrow_flg : wide_flg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      flags <= '0;
      dir_q <= 1'b0;
    end else begin
      dout  <= nxt_val;
      flags <= nxt_flg;
      dir_q <= to_half;
    end
  end

  // R3
  widen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_q |-> flags[2:0] == 3'b000);
  // R4
  widen_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_half && wide_nan) |=> (dout[30:23] == 8'hFF && dout[22:0] != '0));
  // R5
  narrow_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_half && narrow_nan) |=> (dout[14:10] == 5'h1F && dout[9:0] != '0 && dout[31:16] == '0));
  // R6
  invalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3] |-> $past(nan_sel));
  // R8
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] |-> (flags[0] && dout[14:0] == 15'h7C00));
  // R9
  unf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] |-> flags[0]);
endmodule

// File: tb/tb_fp_hs_conv.sv
`timescale 1ns/1ps
module tb_fp_hs_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        to_half = 1'b0;
  logic [31:0] din = '0;
  wire  [31:0] dout;
  wire  [3:0]  flags;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1F2E3D4C;

  always #10 clk = ~clk;

  fp_hs_conv dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .to_half (to_half),
    .din     (din),
    .dout    (dout),
    .flags   (flags)
  );

  typedef struct packed {
    logic        md;
    logic [31:0] op;
    logic [31:0] qd;
    logic [3:0]  qf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hABCD3C00, 32'h3F800000, 4'b0000, 4'd2},
    '{1'b0, 32'h00000001, 32'h33800000, 4'b0000, 4'd3},
    '{1'b0, 32'h0000FC00, 32'hFF800000, 4'b0000, 4'd3},
    '{1'b0, 32'h00008000, 32'h80000000, 4'b0000, 4'd3},
    '{1'b0, 32'h00007E00, 32'h7FC00000, 4'b0000, 4'd4},
    '{1'b0, 32'h0000FD55, 32'hFFA00055, 4'b1000, 4'd6},
    '{1'b1, 32'h3F800000, 32'h00003C00, 4'b0000, 4'd2},
    '{1'b1, 32'h7F800000, 32'h00007C00, 4'b0000, 4'd7},
    '{1'b1, 32'h7FC00000, 32'h00007E00, 4'b0000, 4'd5},
    '{1'b1, 32'h7F800100, 32'h00007C01, 4'b1000, 4'd5},
    '{1'b1, 32'hFFA000AA, 32'h0000FDAA, 4'b1000, 4'd6},
    '{1'b1, 32'h47800000, 32'h00007C00, 4'b0101, 4'd8},
    '{1'b1, 32'h477FF000, 32'h00007C00, 4'b0101, 4'd8},
    '{1'b1, 32'h3F801000, 32'h00003C00, 4'b0001, 4'd7},
    '{1'b1, 32'h3F803000, 32'h00003C02, 4'b0001, 4'd7},
    '{1'b1, 32'h33800000, 32'h00000001, 4'b0000, 4'd9},
    '{1'b1, 32'h33000000, 32'h00000000, 4'b0011, 4'd9},
    '{1'b1, 32'h33C00000, 32'h00000002, 4'b0011, 4'd9},
    '{1'b1, 32'h387FE000, 32'h00000400, 4'b0011, 4'd9},
    '{1'b1, 32'h00000001, 32'h00000000, 4'b0011, 4'd9},
    '{1'b1, 32'h80000000, 32'h00008000, 4'b0000, 4'd7},
    '{1'b1, 32'hC7800000, 32'h0000FC00, 4'b0101, 4'd8}
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual dout=%h flags=%b expected dout=%h flags=%b",
               req, act[35:4], act[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  task automatic next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
  endtask

  // reference: half to single by stepwise normalisation
  function automatic logic [35:0] ref_widen(input logic [15:0] h);
    logic        s;
    logic [4:0]  e;
    logic [10:0] mm;
    int          ex;
    s  = h[15];
    e  = h[14:10];
    mm = {1'b0, h[9:0]};
    if (e == 5'h1F) begin
      if (mm == 0) return {s, 8'hFF, 23'b0, 4'b0000};
      return {s, 8'hFF, h[9:8], 13'b0, h[7:0], ~h[9], 3'b000};
    end
    if (e == 0) begin
      if (mm == 0) return {s, 31'b0, 4'b0000};
      ex = -14;
      while (!mm[10]) begin
        mm = mm << 1;
        ex = ex - 1;
      end
      return {s, 8'(ex + 127), mm[9:0], 13'b0, 4'b0000};
    end
    return {s, 8'(int'(e) - 15 + 127), h[9:0], 13'b0, 4'b0000};
  endfunction

  // reference: single to half by bit-serial right shift and rounding
  function automatic logic [35:0] ref_narrow(input logic [31:0] f);
    logic       s, g, st;
    int         ee, ue, drop, mag;
    longint     sig;
    logic [9:0] p;
    s = f[31];
    if (f[30:23] == 8'hFF) begin
      if (f[22:0] == 0) return {16'b0, s, 15'h7C00, 4'b0000};
      p = {f[22:21], f[7:0]};
      if (p == 0) p = 10'd1;
      return {16'b0, s, 5'h1F, p, ~f[22], 3'b000};
    end
    ue  = (f[30:23] == 0) ? -126 : int'(f[30:23]) - 127;
    sig = (f[30:23] == 0) ? longint'(f[22:0]) : longint'(f[22:0]) + 64'sd8388608;
    if (sig == 0) return {16'b0, s, 15'b0, 4'b0000};
    ee   = (ue < -14) ? -14 : ue;
    drop = 13 + (ee - ue);
    g = 1'b0;
    st = 1'b0;
    for (int i = 0; i < drop; i++) begin
      st  = st | g;
      g   = sig[0];
      sig = sig >>> 1;
    end
    if (g && (st || sig[0])) sig = sig + 1;
    mag = (ee + 14) * 1024 + int'(sig);
    if (mag >= 31744) return {16'b0, s, 15'h7C00, 4'b0101};
    return {16'b0, s, 15'(mag), 1'b0, 1'b0, (ue < -14) && (g || st), g || st};
  endfunction

  initial begin
    logic [35:0] ex;
    string tag;
    @(negedge clk);
    to_half = 1'b1;
    din = 32'h3F800000;
    #1 chk("R1 reset value", {dout, flags}, 36'h0);
    @(negedge clk);
    chk("R1 reset held across edge", {dout, flags}, 36'h0);
    rst_n = 1'b1;

    // R2: registered, previous value still present right after input change
    to_half = 1'b1;
    din = 32'h3F800000;
    #1 chk("R2 not yet updated", {dout, flags}, 36'h0);
    @(negedge clk);
    chk("R2 one cycle latency", {dout, flags}, {32'h00003C00, 4'b0000});

    for (int i = 0; i < NV; i++) begin
      to_half = VECS[i].md;
      din = VECS[i].op;
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), {dout, flags}, {VECS[i].qd, VECS[i].qf});
    end

    // exhaustive half-to-single with noise in ignored upper bits
    for (int i = 0; i < 65536; i++) begin
      next_rand();
      to_half = 1'b0;
      din = {seed[15:0], 16'(i)};
      @(negedge clk);
      ex = ref_widen(16'(i));
      if ((i & 16'h7C00) == 16'h7C00 && (i & 16'h03FF) != 0) tag = ex[3] ? "R6 widen sNaN" : "R4 widen NaN";
      else tag = "R3 widen";
      chk(tag, {dout, flags}, ex);
    end

    // single-to-half: random plus random in the half exponent range
    for (int i = 0; i < 40000; i++) begin
      logic [31:0] v;
      next_rand();
      v = seed;
      if (i % 2 == 1) v[30:23] = 8'(95 + int'(seed % 32'd52));
      to_half = 1'b1;
      din = v;
      @(negedge clk);
      ex = ref_narrow(v);
      if (v[30:23] == 8'hFF && v[22:0] != 0) tag = ex[3] ? "R6 narrow sNaN" : "R5 narrow NaN";
      else if (ex[2]) tag = "R8 overflow";
      else if (v[30:23] <= 8'd112) tag = "R9 tiny";
      else tag = "R7 rounding";
      chk(tag, {dout, flags}, ex);
    end

    // R1: asynchronous reset clears a flagged result
    to_half = 1'b1;
    din = 32'h7F800100;
    @(negedge clk);
    chk("R6 before reset", {dout, flags}, {32'h00007C01, 4'b1000});
    rst_n = 1'b0;
    #1 chk("R1 async clear", {dout, flags}, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 after reset release", {dout, flags}, {32'h00007C01, 4'b1000});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule